// File: doc/BRIEF.md
# Branch Predictor with Target Buffer

This block predicts control flow for a five-stage in-order RISC-V pipeline. One of three prediction schemes is chosen at elaboration through a mode parameter.

In the two decode-side modes, the decode stage presents the instruction PC, its class and its sign-extended offset. The block answers in the same cycle with a speculative redirect and the redirect address.
- The static mode applies a fixed rule: jumps and backward conditional branches are taken.
- The history mode replaces the rule for conditional branches with a direct-mapped table of 2-bit saturating counters.

In the target-buffer mode, the fetch PC is looked up in a direct-mapped table. Each entry holds a full PC tag, a target and a 2-bit counter. A predicted-taken hit returns the target in the same cycle, so fetch can redirect with no bubble.

In every mode, the branch unit reports each resolved branch on the update port.

Top module: `branch_predictor`

## Requirements
- R1: In static mode, `dec_redirect_o` is 1 when `dec_is_jal_i` is 1, or when `dec_is_cond_i` is 1 and bit 31 of `dec_offset_i` is 1 (backward branch). Otherwise it is 0. `dec_target_o` equals `dec_pc_i + dec_offset_i` when redirecting and 0 otherwise.
- R2: Outputs that belong to the modes not selected are held at 0. In decode-side modes that means `fetch_taken_o` and `fetch_target_o`; in target-buffer mode it means `dec_redirect_o` and `dec_target_o`.
- R3: In history mode every counter resets to 1 (weakly not taken). A conditional branch redirects when the counter indexed by `dec_pc_i` is 2 or 3. A JAL always redirects. The target follows the rule of R1.
- R4: On each `upd_valid_i`, a counter steps up by one on taken and down by one on not-taken, saturating at 0 and at 3.
- R5: The table index is PC bits [IDX_W+1:2]. In history mode there is no tag, so two PCs with equal index bits share one counter.
- R6: In target-buffer mode, a lookup hits only when the indexed entry is valid and its stored 32-bit PC equals `fetch_pc_i`. `fetch_taken_o` is 1 on a hit whose counter is 2 or 3, in the same cycle. `fetch_target_o` then carries the stored target and is 0 otherwise.
- R7: A taken update that misses writes its entry with the PC, the target and counter value 2, and marks it valid. This replaces any other branch that held that index.
- R8: A not-taken update that misses leaves the table unchanged.
- R9: An update that hits adjusts the entry's counter per R4. A taken update that hits also rewrites the stored target.
- R10: Reset clears every valid bit, so no lookup hits until a taken branch has been recorded.
- R11: An update becomes visible to lookups from the next cycle. A lookup in the same cycle as an update sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | XLEN | Fetch-stage PC for the target-buffer lookup |
| fetch_taken_o | output | 1 | Fetch-stage predicted taken |
| fetch_target_o | output | XLEN | Fetch-stage predicted target |
| dec_pc_i | input | XLEN | PC of the instruction in decode |
| dec_is_cond_i | input | 1 | Decode: instruction is a conditional branch |
| dec_is_jal_i | input | 1 | Decode: instruction is a JAL |
| dec_offset_i | input | XLEN | Decode: sign-extended branch/jump offset |
| dec_redirect_o | output | 1 | Decode-stage speculative redirect |
| dec_target_o | output | XLEN | Decode-stage redirect address |
| upd_valid_i | input | 1 | A resolved branch is reported this cycle |
| upd_pc_i | input | XLEN | PC of the resolved branch |
| upd_taken_i | input | 1 | Resolved direction |
| upd_target_i | input | XLEN | Resolved target |

## Verification
The bench targets several corner cases, each chosen because a specific bug would show up there:
- **Tag aliasing.** A PC that shares index bits with a stored branch is checked for a miss. A tag compare on only the index bits would wrongly predict that alias taken.
- **Not-taken miss.** Such an update is checked for leaving the table alone. A design that allocates on it would drop the entry already held at that index.
- **Replacement and target rewrite.** Overwriting by a taken miss, and rewriting the target on a taken hit, are both checked. Counters are also driven into both saturation limits. A wrapping counter would flip a strongly-taken prediction after one more taken branch.
- **Same-cycle update.** A lookup in the same cycle as an update must return the old contents. This exposes write-through forwarding that was not asked for.
- **History-table sharing.** Aliasing PCs in history mode must share one counter. A design that tags or splits that table would predict them independently.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    BP_STATIC  = 2'd0,
    BP_HISTORY = 2'd1,
    BP_TARGET  = 2'd2
  } bp_mode_e;

  // 2-bit saturating counter step
  function automatic logic [1:0] ctr_next(logic [1:0] c, logic taken);
    if (taken) return (c == 2'd3) ? c : c + 2'd1;
    else       return (c == 2'd0) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/bp_decode_rule.sv
module bp_decode_rule #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            is_cond_i,
  input  logic            is_jal_i,
  input  logic [XLEN-1:0] offset_i,
  input  logic            cond_taken_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] target_o
);
  always_comb begin
    redirect_o = is_jal_i | (is_cond_i & cond_taken_i);
    target_o   = redirect_o ? pc_i + offset_i : '0;
  end
endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table import bp_pkg::*; #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] look_pc_i,
  output logic            ctr_taken_o,
  input  logic            upd_valid_i,
  input  logic [XLEN-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [1:0]       ctr_q [ENTRIES];
  logic [IDX_W-1:0] look_idx, upd_idx;
  logic [1:0]       upd_ctr;

  assign look_idx    = look_pc_i[IDX_W+1:2];
  assign upd_idx     = upd_pc_i[IDX_W+1:2];
  assign upd_ctr     = ctr_q[upd_idx];
  assign ctr_taken_o = ctr_q[look_idx][1];

  logic unused_bits;
  assign unused_bits = ^{look_pc_i[XLEN-1:IDX_W+2], look_pc_i[1:0],
                         upd_pc_i[XLEN-1:IDX_W+2], upd_pc_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= 2'd1;
    end else if (upd_valid_i) begin
      ctr_q[upd_idx] <= ctr_next(upd_ctr, upd_taken_i);
    end
  end

  a_r4_ctr_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && upd_ctr != 2'd3)
      |=> ctr_q[$past(upd_idx)] == $past(upd_ctr) + 2'd1);

  a_r4_ctr_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i && upd_ctr == 2'd0)
      |=> ctr_q[$past(upd_idx)] == 2'd0);
endmodule

// File: rtl/bp_target_buffer.sv
module bp_target_buffer import bp_pkg::*; #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] fetch_pc_i,
  output logic            taken_o,
  output logic [XLEN-1:0] target_o,
  input  logic            upd_valid_i,
  input  logic [XLEN-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [XLEN-1:0] upd_target_i
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [XLEN-1:0]    tag_q [ENTRIES];
  logic [XLEN-1:0]    tgt_q [ENTRIES];
  logic [1:0]         ctr_q [ENTRIES];

  logic [IDX_W-1:0] f_idx, u_idx;
  logic             f_hit, u_hit, alloc;

  assign f_idx = fetch_pc_i[IDX_W+1:2];
  assign u_idx = upd_pc_i[IDX_W+1:2];
  assign f_hit = valid_q[f_idx] && (tag_q[f_idx] == fetch_pc_i);
  assign u_hit = valid_q[u_idx] && (tag_q[u_idx] == upd_pc_i);
  assign alloc = upd_valid_i && upd_taken_i && !u_hit;

  assign taken_o  = f_hit && ctr_q[f_idx][1];
  assign target_o = taken_o ? tgt_q[f_idx] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    valid_q <= '0;
    else if (alloc) valid_q[u_idx] <= 1'b1;
  end

  // payload needs no reset: gated by valid_q
  always_ff @(posedge clk_i) begin
    if (alloc) begin
      tag_q[u_idx] <= upd_pc_i;
      tgt_q[u_idx] <= upd_target_i;
      ctr_q[u_idx] <= 2'd2;
    end else if (upd_valid_i && u_hit) begin
      ctr_q[u_idx] <= ctr_next(ctr_q[u_idx], upd_taken_i);
      if (upd_taken_i) tgt_q[u_idx] <= upd_target_i;
    end
  end

  a_r7_alloc_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i) |=> valid_q[$past(u_idx)]);

  a_r7_alloc_ctr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && !u_hit) |=> ctr_q[$past(u_idx)] == 2'd2);

  a_r8_no_alloc_nt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i && !u_hit) |=> $stable(valid_q));
endmodule

// File: rtl/branch_predictor.sv
module branch_predictor import bp_pkg::*; #(
  parameter bp_mode_e MODE  = BP_TARGET,
  parameter int       XLEN  = 32,
  parameter int       IDX_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] fetch_pc_i,
  output logic            fetch_taken_o,
  output logic [XLEN-1:0] fetch_target_o,
  input  logic [XLEN-1:0] dec_pc_i,
  input  logic            dec_is_cond_i,
  input  logic            dec_is_jal_i,
  input  logic [XLEN-1:0] dec_offset_i,
  output logic            dec_redirect_o,
  output logic [XLEN-1:0] dec_target_o,
  input  logic            upd_valid_i,
  input  logic [XLEN-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [XLEN-1:0] upd_target_i
);
  if (MODE == BP_TARGET) begin : g_btb
    bp_target_buffer #(.XLEN(XLEN), .IDX_W(IDX_W)) u_btb (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .fetch_pc_i   (fetch_pc_i),
      .taken_o      (fetch_taken_o),
      .target_o     (fetch_target_o),
      .upd_valid_i  (upd_valid_i),
      .upd_pc_i     (upd_pc_i),
      .upd_taken_i  (upd_taken_i),
      .upd_target_i (upd_target_i)
    );
    assign dec_redirect_o = 1'b0;
    assign dec_target_o   = '0;
    logic unused_dec;
    assign unused_dec = ^{dec_pc_i, dec_is_cond_i, dec_is_jal_i, dec_offset_i};
  end else begin : g_dec
    logic cond_taken;
    if (MODE == BP_HISTORY) begin : g_hist
      bp_hist_table #(.XLEN(XLEN), .IDX_W(IDX_W)) u_hist (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .look_pc_i   (dec_pc_i),
        .ctr_taken_o (cond_taken),
        .upd_valid_i (upd_valid_i),
        .upd_pc_i    (upd_pc_i),
        .upd_taken_i (upd_taken_i)
      );
      logic unused_fetch;
      assign unused_fetch = ^{fetch_pc_i, upd_target_i};
    end else begin : g_static
      assign cond_taken = dec_offset_i[XLEN-1];
      logic unused_static;
      assign unused_static = ^{fetch_pc_i, upd_valid_i, upd_pc_i, upd_taken_i,
                               upd_target_i, clk_i, rst_ni};
    end
    bp_decode_rule #(.XLEN(XLEN)) u_rule (
      .pc_i         (dec_pc_i),
      .is_cond_i    (dec_is_cond_i),
      .is_jal_i     (dec_is_jal_i),
      .offset_i     (dec_offset_i),
      .cond_taken_i (cond_taken),
      .redirect_o   (dec_redirect_o),
      .target_o     (dec_target_o)
    );
    assign fetch_taken_o  = 1'b0;
    assign fetch_target_o = '0;
  end

  if (MODE == BP_STATIC) begin : g_chk_static
    a_r1_backward: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_is_cond_i && dec_offset_i[XLEN-1]) |-> dec_redirect_o);
  end
endmodule

// File: tb/tb_branch_predictor.sv
`timescale 1ns/1ps
module tb_branch_predictor;
  import bp_pkg::*;
  localparam int XLEN  = 32;
  localparam int IDX_W = 4;
  localparam int ENT   = 1 << IDX_W;
  localparam logic [31:0] PA = 32'h0000_1000;
  localparam logic [31:0] PB = PA + 32'd64;  // same index as PA

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] f_pc, d_pc, d_off, u_pc, u_tgt;
  logic        d_cond, d_jal, u_val, u_tk;

  logic        bt_ft, st_ft, hi_ft, bt_dr, st_dr, hi_dr;
  logic [31:0] bt_fg, st_fg, hi_fg, bt_dt, st_dt, hi_dt;

  branch_predictor #(.MODE(BP_TARGET), .XLEN(XLEN), .IDX_W(IDX_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(f_pc), .fetch_taken_o(bt_ft),
    .fetch_target_o(bt_fg), .dec_pc_i(d_pc), .dec_is_cond_i(d_cond),
    .dec_is_jal_i(d_jal), .dec_offset_i(d_off), .dec_redirect_o(bt_dr),
    .dec_target_o(bt_dt), .upd_valid_i(u_val), .upd_pc_i(u_pc),
    .upd_taken_i(u_tk), .upd_target_i(u_tgt));
  branch_predictor #(.MODE(BP_STATIC), .XLEN(XLEN), .IDX_W(IDX_W)) dut_st (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(f_pc), .fetch_taken_o(st_ft),
    .fetch_target_o(st_fg), .dec_pc_i(d_pc), .dec_is_cond_i(d_cond),
    .dec_is_jal_i(d_jal), .dec_offset_i(d_off), .dec_redirect_o(st_dr),
    .dec_target_o(st_dt), .upd_valid_i(u_val), .upd_pc_i(u_pc),
    .upd_taken_i(u_tk), .upd_target_i(u_tgt));
  branch_predictor #(.MODE(BP_HISTORY), .XLEN(XLEN), .IDX_W(IDX_W)) dut_hi (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(f_pc), .fetch_taken_o(hi_ft),
    .fetch_target_o(hi_fg), .dec_pc_i(d_pc), .dec_is_cond_i(d_cond),
    .dec_is_jal_i(d_jal), .dec_offset_i(d_off), .dec_redirect_o(hi_dr),
    .dec_target_o(hi_dt), .upd_valid_i(u_val), .upd_pc_i(u_pc),
    .upd_taken_i(u_tk), .upd_target_i(u_tgt));

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // reference state
  bit          m_v [ENT];
  logic [31:0] m_tag [ENT], m_tgt [ENT];
  logic [1:0]  m_c [ENT], h_c [ENT];

  function automatic int ix(logic [31:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction
  function automatic logic [1:0] sat(logic [1:0] c, logic t);
    if (t) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(logic [31:0] fpc, logic [31:0] dpc, logic dc, logic dj,
                       logic [31:0] doff, logic uv, logic [31:0] upc, logic ut,
                       logic [31:0] utg);
    f_pc = fpc; d_pc = dpc; d_cond = dc; d_jal = dj; d_off = doff;
    u_val = uv; u_pc = upc; u_tk = ut; u_tgt = utg;
    #1;
  endtask

  // compare all three instances against the reference
  task automatic cmp_all();
    int i;
    logic hit, tk, sr, hr;
    i   = ix(f_pc);
    hit = m_v[i] && (m_tag[i] == f_pc);
    tk  = hit && m_c[i][1];
    chk("R6 btb taken", {31'd0, bt_ft}, {31'd0, tk});
    chk("R6 btb target", bt_fg, tk ? m_tgt[i] : 32'd0);
    sr = d_jal | (d_cond & d_off[31]);
    chk("R1 static redirect", {31'd0, st_dr}, {31'd0, sr});
    chk("R1 static target", st_dt, sr ? d_pc + d_off : 32'd0);
    hr = d_jal | (d_cond & h_c[ix(d_pc)][1]);
    chk("R3 hist redirect", {31'd0, hi_dr}, {31'd0, hr});
    chk("R3 hist target", hi_dt, hr ? d_pc + d_off : 32'd0);
    chk("R2 quiet outputs", {bt_dr, st_ft, hi_ft, 29'd0}, 32'd0);
    chk("R2 quiet targets", bt_dt | st_fg | hi_fg, 32'd0);
  endtask

  task automatic commit();
    int i;
    logic hit;
    if (u_val) begin
      h_c[ix(u_pc)] = sat(h_c[ix(u_pc)], u_tk);
      i   = ix(u_pc);
      hit = m_v[i] && (m_tag[i] == u_pc);
      if (hit) begin
        m_c[i] = sat(m_c[i], u_tk);
        if (u_tk) m_tgt[i] = u_tgt;
      end else if (u_tk) begin
        m_v[i] = 1'b1; m_tag[i] = u_pc; m_tgt[i] = u_tgt; m_c[i] = 2'd2;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < ENT; i++) begin
      m_v[i] = 1'b0; m_c[i] = 2'd0; h_c[i] = 2'd1; m_tag[i] = '0; m_tgt[i] = '0;
    end
    drive(PA, PA, 1'b0, 1'b0, 32'd0, 1'b0, PA, 1'b0, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state, static backward, same-cycle update invisible
    drive(PA, PA, 1'b1, 1'b0, 32'hFFFF_FFF8, 1'b1, PA, 1'b1, 32'h2000);
    chk("R10 no hit after reset", {31'd0, bt_ft}, 32'd0);
    chk("R11 update not yet visible", bt_fg, 32'd0);
    chk("R3 reset counter weak not-taken", {31'd0, hi_dr}, 32'd0);
    chk("R1 backward branch taken", st_dt, 32'h0000_0FF8);
    cmp_all(); commit();

    // allocated entry hits; history counter now 2; forward branch not taken
    drive(PA, PA, 1'b1, 1'b0, 32'd16, 1'b0, PA, 1'b0, 32'd0);
    chk("R7 alloc hit taken", {31'd0, bt_ft}, 32'd1);
    chk("R7 alloc target", bt_fg, 32'h2000);
    chk("R4 counter stepped up", {31'd0, hi_dr}, 32'd1);
    chk("R1 forward branch not taken", {31'd0, st_dr}, 32'd0);
    cmp_all(); commit();

    // alias: tag mismatch; history shares counter; not-taken miss
    drive(PB, PB, 1'b1, 1'b0, 32'd8, 1'b1, PB, 1'b0, 32'h5000);
    chk("R6 alias tag miss", {31'd0, bt_ft}, 32'd0);
    chk("R5 alias shares counter", {31'd0, hi_dr}, 32'd1);
    cmp_all(); commit();

    drive(PA, PA, 1'b1, 1'b0, 32'd8, 1'b1, PB, 1'b1, 32'h3000);
    chk("R8 not-taken miss kept entry", bt_fg, 32'h2000);
    chk("R4 counter stepped down", {31'd0, hi_dr}, 32'd0);
    cmp_all(); commit();

    drive(PA, PA, 1'b0, 1'b1, 32'd40, 1'b1, PB, 1'b0, 32'd0);
    chk("R7 overwritten by alias", {31'd0, bt_ft}, 32'd0);
    chk("R3 jal always redirects", hi_dt, PA + 32'd40);
    cmp_all(); commit();

    drive(PB, PA, 1'b0, 1'b1, 32'd4, 1'b1, PB, 1'b1, 32'h4000);
    chk("R9 hit counter decremented", {31'd0, bt_ft}, 32'd0);
    chk("R1 jal forward taken", {31'd0, st_dr}, 32'd1);
    cmp_all(); commit();

    drive(PB, PA, 1'b0, 1'b0, 32'd4, 1'b1, PB, 1'b1, 32'h4000);
    chk("R9 target rewritten on hit", bt_fg, 32'h4000);
    chk("R1 non-branch no redirect", {31'd0, st_dr}, 32'd0);
    cmp_all(); commit();

    // saturation at 3, then a single not-taken keeps prediction
    for (int k = 0; k < 3; k++) begin
      drive(PB, PB, 1'b1, 1'b0, 32'd4, 1'b1, PB, 1'b1, 32'h4000);
      cmp_all(); commit();
    end
    drive(PB, PB, 1'b1, 1'b0, 32'd4, 1'b1, PB, 1'b0, 32'd0);
    cmp_all(); commit();
    drive(PB, PB, 1'b1, 1'b0, 32'd4, 1'b0, PB, 1'b0, 32'd0);
    chk("R4 saturated btb counter", {31'd0, bt_ft}, 32'd1);
    chk("R4 saturated hist counter", {31'd0, hi_dr}, 32'd1);
    cmp_all(); commit();

    // floor at 0: four not-taken then one taken gives counter 1
    for (int k = 0; k < 4; k++) begin
      drive(PB, PB, 1'b1, 1'b0, 32'd4, 1'b1, PB, 1'b0, 32'd0);
      cmp_all(); commit();
    end
    drive(PB, PB, 1'b1, 1'b0, 32'd4, 1'b1, PB, 1'b1, 32'h4000);
    cmp_all(); commit();
    drive(PB, PB, 1'b1, 1'b0, 32'd4, 1'b0, PB, 1'b0, 32'd0);
    chk("R4 floor then one taken", {31'd0, hi_dr}, 32'd0);
    cmp_all(); commit();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] fp, dp, up, off;
      logic [1:0]  cls;
      fp  = 32'h1000 + ($urandom % 8) * 4 + ($urandom % 2) * 64;
      dp  = 32'h1000 + ($urandom % 8) * 4 + ($urandom % 2) * 64;
      up  = 32'h1000 + ($urandom % 8) * 4 + ($urandom % 2) * 64;
      off = {{20{1'b0}}, 12'($urandom)} - 32'd2048;
      cls = 2'($urandom % 3);
      drive(fp, dp, cls == 2'd1, cls == 2'd2, off, ($urandom % 4) != 0, up,
            ($urandom % 3) != 0, 32'h8000 + ($urandom % 64) * 4);
      cmp_all(); commit();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule